// File: doc/BRIEF.md
# I2C Strap-Addressed Register-Write Slave

This block is the receive side of a two-wire serial slave. It accepts write frames only. It works out its own 7-bit bus address from a handful of strap pins and a mode pin. The address is captured while reset is held and is frozen once reset is released. After that, the slave watches the bus for frames addressed to it. The second byte of a frame selects a register. Every later byte in the same frame is written to that one register, and the register address does not step between bytes. This lets a host stream many bytes into a single port, such as a FIFO, inside one frame.

SCL and SDA are resynchronised into the system clock domain, and bus events are found by sampling them. The slave pulls SDA low through an open-drain enable to acknowledge the bytes it accepts.

The write port is a plain strobe, with no ready signal. The bus offers no way to pause the host without clock stretching, so the consumer must accept every strobe in the cycle it appears. There is no back-pressure.

Top module: `i2c_strap_wr_slave`

## Requirements
- R1: While reset is asserted and after it is released, `sda_oe`, `wr_valid`, `reg_addr` and `wr_data` are all 0 until a frame is received.
- R2: With `full_strap` low, the bus address is binary 0101 in bits 6..3, and `strap[2:0]` fills bits 2..0.
- R3: With `full_strap` high, the bus address is `strap[6:0]`. When the parameter `FORCE_B6_ZERO` is 1, address bit 6 is 0 whatever the level of `strap[6]`.
- R4: `full_strap` and `strap` are captured on the last clock edge before reset is released. Later changes on those pins have no effect on the address.
- R5: The first byte after a START is sent MSB first. Its bits 7..1 are the bus address and bit 0 is R/W. The slave acknowledges this byte only when bits 7..1 equal its address and bit 0 is 0.
- R6: After an address mismatch, or after R/W = 1, the slave never drives SDA and never strobes until the next START.
- R7: In an accepted frame, the slave pulls SDA low during the ninth SCL clock of the register byte and of every data byte.
- R8: The second byte of an accepted frame appears on `reg_addr`. Each later byte appears on `wr_data` together with a `wr_valid` pulse. `reg_addr` keeps the same value for all data bytes of that frame.
- R9: A STOP, or a repeated START, in the middle of a byte discards the partial byte and produces no strobe. A repeated START restarts address decoding. After a STOP, bytes are ignored until the next START.
- R10: A frame that ends after the register byte produces no `wr_valid` pulse.
- R11: `wr_valid` is high for exactly one system clock per data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset; straps are captured while it is low |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level, as seen on the wire |
| sda_oe | output | 1 | When high, the slave pulls SDA low (open drain) |
| full_strap | input | 1 | Address mode: 0 = fixed upper nibble, 1 = all bits from straps |
| strap | input | 7 | Address strap pins |
| reg_addr | output | 8 | Register address of the current frame |
| wr_data | output | 8 | Last data byte received |
| wr_valid | output | 1 | One-cycle write strobe for each data byte |

## Verification
The bench builds two copies of the block that share SCL and the strap pins. Each copy sees SDA through its own open-drain wire. `u0` uses the defaults, with `FORCE_B6_ZERO` = 0 and two synchroniser stages. `u1` sets `FORCE_B6_ZERO` = 1. With full strapping and the strap pins at 0x5A, the two copies answer to different addresses, 0x5A and 0x1A. Sending the same frames to both therefore shows, acknowledge by acknowledge, that the pin-derived bit 6 and the forced-zero bit 6 behave differently. In fixed-nibble mode the two copies must agree.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  localparam int ADDR_W  = 7;
  localparam int BYTE_W  = 8;
  localparam int FIX_W   = 4;
  localparam logic [FIX_W-1:0] FIX_VAL = 4'b0101;
  localparam int CNT_W   = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_REG,
    PH_DATA,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/i2cw_sync.sv
module i2cw_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl_s, sda_s, scl_d, sda_d;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= scl_i;
          sda_sh <= sda_i;
        end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) begin
          scl_sh <= '1;
          sda_sh <= '1;
        end else begin
          scl_sh <= {scl_sh[STAGES-2:0], scl_i};
          sda_sh <= {sda_sh[STAGES-2:0], sda_i};
        end
    end
  endgenerate

  assign scl_s = scl_sh[STAGES-1];
  assign sda_s = sda_sh[STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end

  assign sda_lvl  = sda_s;
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;

  assert_start_stop_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ev && stop_ev));
endmodule

// File: rtl/i2cw_strap.sv
module i2cw_strap
  import i2cw_pkg::*;
#(
  parameter bit FORCE_B6_ZERO = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full_strap,
  input  logic [ADDR_W-1:0] strap,
  output logic [ADDR_W-1:0] dev_addr
);
  logic [ADDR_W-1:0] cand;

  always_comb begin
    if (full_strap) begin
      cand = strap;
      if (FORCE_B6_ZERO) cand[ADDR_W-1] = 1'b0;
    end else begin
      cand = {FIX_VAL, strap[ADDR_W-FIX_W-1:0]};
    end
  end

  // Loaded on every edge while reset is held; frozen after release.
  always_ff @(posedge clk)
    if (!rst_n) dev_addr <= cand;

  assert_addr_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> $stable(dev_addr));
endmodule

// File: rtl/i2cw_frame.sv
module i2cw_frame
  import i2cw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [ADDR_W-1:0] dev_addr,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              wr_valid
);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);

  phase_e            ph_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] sh_q;
  logic              ack_q;
  logic              live;

  assign live = (ph_q != PH_IDLE) && (ph_q != PH_SKIP);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph_q     <= PH_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      ack_q    <= 1'b0;
      reg_addr <= '0;
      wr_data  <= '0;
      wr_valid <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      if (start_ev) begin
        ph_q  <= PH_ADDR;
        cnt_q <= '0;
        ack_q <= 1'b0;
      end else if (stop_ev) begin
        ph_q  <= PH_IDLE;
        cnt_q <= '0;
        ack_q <= 1'b0;
      end else if (live) begin
        if (scl_rise && cnt_q < CNT_FULL) begin
          sh_q  <= {sh_q[BYTE_W-2:0], sda_lvl};
          cnt_q <= cnt_q + 1'b1;
        end else if (scl_fall && cnt_q == CNT_FULL) begin
          if (ack_q) begin
            ack_q <= 1'b0;
            cnt_q <= '0;
            if (ph_q == PH_ADDR)     ph_q <= PH_REG;
            else if (ph_q == PH_REG) ph_q <= PH_DATA;
          end else begin
            unique case (ph_q)
              PH_ADDR: begin
                if (sh_q[BYTE_W-1:1] == dev_addr && !sh_q[0]) ack_q <= 1'b1;
                else begin
                  ph_q  <= PH_SKIP;
                  cnt_q <= '0;
                end
              end
              PH_REG: begin
                reg_addr <= sh_q;
                ack_q    <= 1'b1;
              end
              PH_DATA: begin
                wr_data  <= sh_q;
                wr_valid <= 1'b1;
                ack_q    <= 1'b1;
              end
              default: ack_q <= 1'b0;
            endcase
          end
        end
      end
    end

  assign sda_oe = ack_q;

  assert_strobe_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  assert_strobe_in_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (ph_q == PH_DATA));
  assert_quiet_when_skipping_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_SKIP || ph_q == PH_IDLE) |-> !sda_oe);
  assert_ack_on_ninth_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (cnt_q == CNT_FULL));
  assert_restart_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (ph_q == PH_ADDR && cnt_q == '0 && !sda_oe));
endmodule

// File: rtl/i2c_strap_wr_slave.sv
module i2c_strap_wr_slave #(
  parameter bit FORCE_B6_ZERO = 1'b0,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       full_strap,
  input  logic [6:0] strap,
  output logic [7:0] reg_addr,
  output logic [7:0] wr_data,
  output logic       wr_valid
);
  logic       sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
  logic [6:0] dev_addr;

  i2cw_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2cw_strap #(.FORCE_B6_ZERO(FORCE_B6_ZERO)) u_strap (
    .clk(clk), .rst_n(rst_n), .full_strap(full_strap), .strap(strap),
    .dev_addr(dev_addr)
  );

  i2cw_frame u_frame (
    .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
    .dev_addr(dev_addr), .sda_oe(sda_oe), .reg_addr(reg_addr),
    .wr_data(wr_data), .wr_valid(wr_valid)
  );
endmodule

// File: tb/sim_i2c_strap_wr_slave.sv
module sim_i2c_strap_wr_slave;
  localparam int CLK_P = 10;
  localparam int Q     = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, hsda = 1'b1;
  logic full_strap = 1'b0;
  logic [6:0] strap = 7'b1111011;
  logic oe0, oe1, wv0, wv1;
  logic [7:0] ra0, wd0, ra1, wd1;
  wire sda_b0 = hsda & ~oe0;
  wire sda_b1 = hsda & ~oe1;

  int checks = 0, errors = 0;
  int ev0 = 0, hi0 = 0, ev1 = 0;
  logic [7:0] lg_r [64];
  logic [7:0] lg_d [64];
  logic prev_wv0 = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  i2c_strap_wr_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_b0), .sda_oe(oe0),
    .full_strap(full_strap), .strap(strap), .reg_addr(ra0), .wr_data(wd0),
    .wr_valid(wv0)
  );
  i2c_strap_wr_slave #(.FORCE_B6_ZERO(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_b1), .sda_oe(oe1),
    .full_strap(full_strap), .strap(strap), .reg_addr(ra1), .wr_data(wd1),
    .wr_valid(wv1)
  );

  always @(negedge clk) begin
    if (wv0) begin
      hi0 = hi0 + 1;
      if (!prev_wv0) begin
        if (ev0 < 64) begin lg_r[ev0] = ra0; lg_d[ev0] = wd0; end
        ev0 = ev0 + 1;
      end
    end
    prev_wv0 = wv0;
    if (wv1) ev1 = ev1 + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    hsda = 1'b1; wq(Q); scl = 1'b1; wq(Q); hsda = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    hsda = 1'b0; wq(Q); scl = 1'b1; wq(Q); hsda = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      hsda = b[i]; wq(Q); scl = 1'b1; wq(Q); scl = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic a0, output logic a1);
    send_bits(b, 8);
    hsda = 1'b1; wq(Q); scl = 1'b1; wq(Q/2);
    a0 = ~sda_b0; a1 = ~sda_b1;
    wq(Q/2); scl = 1'b0; wq(Q);
  endtask

  task automatic do_reset(input logic mode, input logic [6:0] s);
    rst_n = 1'b0; full_strap = mode; strap = s; wq(6); rst_n = 1'b1; wq(4);
  endtask

  task automatic t_reset();
    wq(3);
    chk(oe0 == 1'b0 && wv0 == 1'b0, "R1 outputs in reset", {oe0, wv0}, 0);
    chk(ra0 == 8'h00 && wd0 == 8'h00, "R1 buses in reset", {ra0, wd0}, 0);
    rst_n = 1'b1; wq(4);
    chk(oe0 == 1'b0 && ra0 == 8'h00 && wd0 == 8'h00, "R1 after release", {oe0, ra0, wd0}, 0);
    strap = 7'b0000110;
  endtask

  task automatic t_low_mode();
    logic a0, a1, okd; int base;
    base = ev0; okd = 1'b1;
    bus_start();
    send_byte({7'h2B, 1'b0}, a0, a1);
    chk(a0, "R2 R5 ack addr 0x2B", a0, 1);
    chk(a1, "R2 fixed nibble forced variant", a1, 1);
    send_byte(8'h12, a0, a1);
    chk(a0, "R7 ack register byte", a0, 1);
    send_byte(8'hA5, a0, a1); okd &= a0;
    send_byte(8'h3C, a0, a1); okd &= a0;
    send_byte(8'h7E, a0, a1); okd &= a0;
    chk(okd, "R7 ack data bytes", okd, 1);
    bus_stop();
    chk(ev0 - base == 3, "R8 strobe count", ev0 - base, 3);
    chk(lg_r[base] == 8'h12 && lg_r[base+1] == 8'h12 && lg_r[base+2] == 8'h12,
        "R8 same register", lg_r[base+2], 8'h12);
    chk(lg_d[base] == 8'hA5 && lg_d[base+1] == 8'h3C && lg_d[base+2] == 8'h7E,
        "R8 data order", lg_d[base+2], 8'h7E);
    chk(hi0 == ev0, "R11 strobe width", hi0, ev0);
  endtask

  task automatic t_frozen_and_mismatch();
    logic a0, a1; int base;
    base = ev0;
    bus_start();
    send_byte({7'h2E, 1'b0}, a0, a1);
    chk(!a0, "R4 late strap ignored", a0, 0);
    send_byte(8'h12, a0, a1);
    chk(!a0, "R6 no ack after mismatch", a0, 0);
    send_byte(8'h55, a0, a1);
    bus_stop();
    chk(ev0 == base, "R6 no strobe after mismatch", ev0 - base, 0);
    bus_start();
    send_byte({7'h2B, 1'b1}, a0, a1);
    chk(!a0, "R5 read bit refused", a0, 0);
    send_byte(8'h33, a0, a1);
    chk(!a0 && ev0 == base, "R6 ignored after read bit", a0, 0);
    bus_stop();
  endtask

  task automatic t_restart_stop();
    logic a0, a1; int base;
    base = ev0;
    bus_start();
    send_byte({7'h2B, 1'b0}, a0, a1);
    send_byte(8'h40, a0, a1);
    send_bits(8'hF0, 5);
    bus_start();
    send_byte({7'h2B, 1'b0}, a0, a1);
    chk(a0, "R9 address after restart", a0, 1);
    send_byte(8'h41, a0, a1);
    send_byte(8'h99, a0, a1);
    send_bits(8'h0F, 3);
    bus_stop();
    chk(ev0 - base == 1, "R9 partial bytes dropped", ev0 - base, 1);
    chk(lg_r[base] == 8'h41 && lg_d[base] == 8'h99, "R9 restart frame data",
        {lg_r[base], lg_d[base]}, 16'h4199);
    send_byte({7'h2B, 1'b0}, a0, a1);
    chk(!a0, "R9 idle after stop", a0, 0);
  endtask

  task automatic t_no_data();
    logic a0, a1; int base;
    base = ev0;
    bus_start();
    send_byte({7'h2B, 1'b0}, a0, a1);
    send_byte(8'h77, a0, a1);
    bus_stop();
    wq(4);
    chk(ev0 == base, "R10 no strobe without data", ev0 - base, 0);
    chk(ra0 == 8'h77, "R8 register address output", ra0, 8'h77);
  endtask

  task automatic t_full_mode();
    logic a0, a1; int b1;
    do_reset(1'b1, 7'h5A);
    chk(oe0 == 1'b0 && ra0 == 8'h00, "R1 after second reset", ra0, 0);
    bus_start();
    send_byte({7'h5A, 1'b0}, a0, a1);
    chk(a0 && !a1, "R3 full strap 0x5A", {a0, a1}, 2);
    bus_stop();
    b1 = ev1;
    bus_start();
    send_byte({7'h1A, 1'b0}, a0, a1);
    chk(!a0 && a1, "R3 forced bit6 0x1A", {a0, a1}, 1);
    send_byte(8'h05, a0, a1);
    send_byte(8'hC3, a0, a1);
    bus_stop();
    chk(ev1 - b1 == 1 && ra1 == 8'h05 && wd1 == 8'hC3, "R3 forced variant write",
        wd1, 8'hC3);
    bus_start();
    send_byte({7'h2B, 1'b0}, a0, a1);
    chk(!a0 && !a1, "R3 fixed nibble unused in full mode", {a0, a1}, 0);
    bus_stop();
  endtask

  initial begin
    t_reset();
    t_low_mode();
    t_frozen_and_mismatch();
    t_restart_stop();
    t_no_data();
    t_full_mode();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule